// File: doc/BRIEF.md
# Cascaded Serial DAC Frame Loader

This block is the host-side master for a string of identical 16-bit serial converters wired in cascade. All converters share one serial clock and one active-low select line. The serial output of each converter feeds the serial input of the next one. A single start strobe captures one code per device and the divider setting. The block then drives one unbroken frame of `NUM_DEV * CODE_W` bits. It finishes with one rising edge of select, which moves every device's shift register into its output register at the same moment.

Device 0 sits next to the controller and device `NUM_DEV-1` at the far end. Bits ripple through every shift register on the way, so the far device's code goes out first, and each code goes out most significant bit first. The serial clock comes from the system clock through a programmable divider. Its high time, its low time, the setup before the first rising edge, the hold after the last falling edge and the recovery time with select high are each exactly one divider period. The divider period is `half_period` system cycles, and a setting of zero counts as one.

Top module: `dac_chain_loader`

## Requirements
- R1: While reset is asserted and after it is released, `sel_n` is 1 and `sclk`, `busy` and `done` are 0.
- R2: Each frame holds `sel_n` at 0 for exactly `NUM_DEV*CODE_W` rising edges of `sclk`.
- R3: After a frame, a model of the cascade holds each device's own code. In that model every device is a `CODE_W`-bit shift register that takes `sdata` on a rising `sclk`, and device k's input is device k-1's MSB. Device k's code is the slice `codes[k*CODE_W +: CODE_W]`, with k=0 nearest the controller.
- R4: `sdata` changes only while `sclk` is 0. It is stable across every rising edge and through every high phase.
- R5: `sclk` is 0 when `sel_n` falls and when it rises, and it stays 0 whenever `sel_n` is 1.
- R6: With P = max(`half_period`,1) sampled at start, `sel_n` is low for exactly P system cycles before the first rising `sclk`. Every high phase and every low phase of `sclk` within the frame also lasts exactly P cycles.
- R7: `sel_n` rises exactly P cycles after the last falling `sclk`. It then stays high for at least P cycles before the next frame lowers it.
- R8: `busy` rises on the cycle after an accepted start. It falls P cycles after `sel_n` rises, in the same cycle that `done` is 1, and `done` lasts exactly one cycle.
- R9: A start strobe while `busy` is 1 has no effect, and changes to `codes` or `half_period` during a frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| codes | input | NUM_DEV*CODE_W | Per-device codes, device k in bits k*CODE_W +: CODE_W |
| half_period | input | DIV_W | Serial clock phase length in system cycles (0 acts as 1) |
| sclk | output | 1 | Serial clock to all devices |
| sdata | output | 1 | Serial data into the nearest device |
| sel_n | output | 1 | Shared active-low select; rising edge loads all devices |
| busy | output | 1 | Frame in progress, including the recovery time |
| done | output | 1 | One-cycle pulse when the frame ends |

## Verification
The bench builds the loader with `NUM_DEV=3`, `CODE_W=16` and `DIV_W=4`. A three-device chain makes the far-first ordering visible, because a swapped or reversed code lands in the wrong middle or end device. The 4-bit divider covers periods 0, 1, 2, 3 and 5, which checks the zero-as-one rule and the multi-cycle phase timing. Back-to-back frames test the recovery gap, and a start strobe with altered inputs in the middle of a frame tests that the frame is not disturbed.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LEAD = 3'd1,
      ST_HIGH = 3'd2,
      ST_LOW  = 3'd3,
      ST_TAIL = 3'd4,
      ST_GAP  = 3'd5
   } dcl_state_e;

   function automatic int unsigned dcl_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dcl_tick_gen.sv
module dcl_tick_gen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] period_i,
   input  logic             run,
   output logic             tick
);

   logic [DIV_W-1:0] period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    period_q <= '0;
      else if (load) period_q <= period_i;
   end

   generate
      if (DIV_W == 1) begin : g_single
         // periods 0 and 1 both mean one cycle per phase
         assign tick = run;
      end else begin : g_count
         logic [DIV_W-1:0] cnt_q;
         logic [DIV_W-1:0] last;

         assign last = (period_q == '0) ? '0 : period_q - 1'b1;
         assign tick = run && (cnt_q == last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (!run) cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/dcl_frame_shifter.sv
module dcl_frame_shifter #(
   parameter int unsigned NUM_DEV = 4,
   parameter int unsigned CODE_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      shift,
   input  logic [NUM_DEV*CODE_W-1:0] codes_i,
   output logic                      msb_o
);

   localparam int unsigned TOTAL = NUM_DEV * CODE_W;

   logic [TOTAL-1:0] packed_frame;
   logic [TOTAL-1:0] frame_q;

   // The far device leaves first, so its slot sits at the top of the frame.
   generate
      for (genvar k = 0; k < NUM_DEV; k++) begin : g_slot
         assign packed_frame[k*CODE_W +: CODE_W] = codes_i[k*CODE_W +: CODE_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frame_q <= '0;
      else if (load)  frame_q <= packed_frame;
      else if (shift) frame_q <= {frame_q[TOTAL-2:0], 1'b0};
   end

   assign msb_o = frame_q[TOTAL-1];

endmodule

// File: rtl/dcl_sequencer.sv
module dcl_sequencer
   import dcl_pkg::*;
#(
   parameter int unsigned TOTAL_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic load,
   output logic shift,
   output logic run,
   output logic sclk,
   output logic sel_n,
   output logic busy,
   output logic done
);

   localparam int unsigned CNT_W = dcl_cnt_w(TOTAL_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL_BITS - 1);

   dcl_state_e       state_q;
   logic [CNT_W-1:0] bit_q;
   logic             sclk_q;
   logic             sel_n_q;
   logic             done_q;
   logic             last_bit;

   assign load     = (state_q == ST_IDLE) && start;
   assign shift    = (state_q == ST_HIGH) && tick;
   assign run      = (state_q != ST_IDLE);
   assign last_bit = (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         sclk_q  <= 1'b0;
         sel_n_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_LEAD;
               sel_n_q <= 1'b0;
               bit_q   <= '0;
            end
            ST_LEAD: if (tick) begin
               state_q <= ST_HIGH;
               sclk_q  <= 1'b1;
            end
            ST_HIGH: if (tick) begin
               sclk_q <= 1'b0;
               if (last_bit) begin
                  state_q <= ST_TAIL;
               end else begin
                  state_q <= ST_LOW;
                  bit_q   <= bit_q + 1'b1;
               end
            end
            ST_LOW: if (tick) begin
               state_q <= ST_HIGH;
               sclk_q  <= 1'b1;
            end
            ST_TAIL: if (tick) begin
               state_q <= ST_GAP;
               sel_n_q <= 1'b1;
            end
            ST_GAP: if (tick) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk  = sclk_q;
   assign sel_n = sel_n_q;
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;

endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader #(
   parameter int unsigned NUM_DEV = 4,
   parameter int unsigned CODE_W  = 16,
   parameter int unsigned DIV_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NUM_DEV*CODE_W-1:0] codes,
   input  logic [DIV_W-1:0]          half_period,
   output logic                      sclk,
   output logic                      sdata,
   output logic                      sel_n,
   output logic                      busy,
   output logic                      done
);

   localparam int unsigned TOTAL_BITS = NUM_DEV * CODE_W;

   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("dac_chain_loader: NUM_DEV must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("dac_chain_loader: CODE_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("dac_chain_loader: DIV_W must be at least 1");
      end
   endgenerate

   logic load;
   logic shift;
   logic run;
   logic tick;

   dcl_sequencer #(
      .TOTAL_BITS(TOTAL_BITS)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .tick (tick),
      .load (load),
      .shift(shift),
      .run  (run),
      .sclk (sclk),
      .sel_n(sel_n),
      .busy (busy),
      .done (done)
   );

   dcl_tick_gen #(
      .DIV_W(DIV_W)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .period_i(half_period),
      .run     (run),
      .tick    (tick)
   );

   dcl_frame_shifter #(
      .NUM_DEV(NUM_DEV),
      .CODE_W (CODE_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .shift  (shift),
      .codes_i(codes),
      .msb_o  (sdata)
   );

endmodule

// File: rtl/dcl_chain_chk.sv
module dcl_chain_chk #(
   parameter int unsigned TOTAL_BITS = 64
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic sclk,
   input logic sdata,
   input logic sel_n,
   input logic busy,
   input logic done
);

   localparam int unsigned CW = $clog2(TOTAL_BITS + 1);

   logic [CW-1:0] rises_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rises_q <= '0;
      else if (sel_n)               rises_q <= '0;
      else if (sclk && !rises_seen) rises_q <= rises_q + 1'b1;
   end

   logic sclk_d;
   logic rises_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk;
   end
   assign rises_seen = sclk_d;

   // R2
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && !$past(sel_n)) |-> ($past(rises_q) == CW'(TOTAL_BITS)));

   // R4
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));

   // R5
   sel_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> !sclk);

   // R5
   idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> !sclk);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && sel_n));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

bind dac_chain_loader dcl_chain_chk #(
   .TOTAL_BITS(NUM_DEV * CODE_W)
) u_chain_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .sclk (sclk),
   .sdata(sdata),
   .sel_n(sel_n),
   .busy (busy),
   .done (done)
);

// File: tb/test_dac_chain_loader.sv
`timescale 1ns/1ps
module test_dac_chain_loader;

   localparam int unsigned NDEV  = 3;
   localparam int unsigned CW    = 16;
   localparam int unsigned DW    = 4;
   localparam int unsigned TOTAL = NDEV * CW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [TOTAL-1:0] codes = '0;
   logic [DW-1:0]    half_period = '0;
   logic sclk, sdata, sel_n, busy, done;

   always #2.5 clk = ~clk;

   dac_chain_loader #(.NUM_DEV(NDEV), .CODE_W(CW), .DIV_W(DW)) i_dac_chain_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
      .half_period(half_period), .sclk(sclk), .sdata(sdata),
      .sel_n(sel_n), .busy(busy), .done(done)
   );

   int n_chk = 0;
   int n_err = 0;
   int frames_sent = 0;
   int frames_seen = 0;

   logic [TOTAL-1:0] exp_q[$];
   int               per_q[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // Driver: pushes the expected frame, then strobes start.
   task automatic send(input logic [TOTAL-1:0] c, input int p, input bit poke);
      while (busy) @(negedge clk);
      exp_q.push_back(c);
      per_q.push_back((p == 0) ? 1 : p);
      frames_sent++;
      codes = c;
      half_period = DW'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", busy, 1);
      if (poke) begin
         repeat (20) @(negedge clk);
         start = 1'b1;
         codes = ~c;
         half_period = DW'(p + 2);
         @(negedge clk);
         start = 1'b0;
         codes = {TOTAL{1'b1}};
      end
   endtask

   // Monitor: models the cascade and the timing, compares at sel_n rise.
   logic [TOTAL-1:0] chain;
   bit   p_sel = 1'b1, p_sclk = 1'b0, p_d = 1'b0, p_done = 1'b0;
   bit   have_prev = 1'b0, dat_bad = 1'b0, idle_clk_bad = 1'b0;
   int   cur_p = 1, last_p = 1, phase = 0, bits = 0, gap_hi = 0, gap_busy = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_sel && !sel_n) begin
            chk(sclk == 1'b0, "R5 sclk low at select fall", sclk, 0);
            if (have_prev) chk(gap_hi >= last_p, "R7 recovery gap", gap_hi, last_p);
            chk(per_q.size() > 0, "R9 unexpected frame", per_q.size(), 1);
            if (per_q.size() > 0) cur_p = per_q.pop_front();
            bits = 0; phase = 1; dat_bad = 1'b0; chain = '0;
         end else if (!sel_n) begin
            if (sclk != p_sclk) begin
               if (sclk) begin
                  chk(phase == cur_p, "R6 setup/low phase", phase, cur_p);
                  chain = {chain[TOTAL-2:0], sdata};
                  bits++;
               end else begin
                  chk(phase == cur_p, "R6 high phase", phase, cur_p);
               end
               phase = 1;
            end else begin
               phase++;
            end
            if (sclk && sdata != p_d) dat_bad = 1'b1;
         end else if (!p_sel && sel_n) begin
            frames_seen++;
            chk(phase == cur_p, "R7 hold before select rise", phase, cur_p);
            chk(sclk == 1'b0, "R5 sclk low at select rise", sclk, 0);
            chk(bits == TOTAL, "R2 rising edges per frame", bits, TOTAL);
            chk(!dat_bad, "R4 data stable while sclk high", dat_bad, 0);
            if (exp_q.size() > 0) begin
               logic [TOTAL-1:0] e;
               e = exp_q.pop_front();
               for (int k = 0; k < NDEV; k++)
                  chk(chain[k*CW +: CW] == e[k*CW +: CW], $sformatf("R3 device %0d code", k),
                      chain[k*CW +: CW], e[k*CW +: CW]);
            end
            gap_hi = 1; gap_busy = busy ? 1 : 0; have_prev = 1'b1; last_p = cur_p;
         end else begin
            gap_hi++;
            if (busy) gap_busy++;
            if (sclk) idle_clk_bad = 1'b1;
         end
         if (done) begin
            chk(busy == 1'b0, "R8 busy low with done", busy, 0);
            chk(gap_busy == cur_p, "R8 busy through recovery", gap_busy, cur_p);
         end
         if (p_done) chk(done == 1'b0, "R8 done single cycle", done, 0);
         p_sel = sel_n; p_sclk = sclk; p_d = sdata; p_done = done;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got %0d cycles expected < 100000", wd);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(sel_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 reset outputs", {sel_n, sclk, busy, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sel_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 idle after reset", {sel_n, sclk, busy, done}, 4'b1000);

      send(48'hA5C3_1234_F00F, 1, 1'b0);
      send(48'h8001_7FFE_5555, 2, 1'b0);
      send(48'hFFFF_0000_FFFF, 3, 1'b0);
      send(48'h0001_8000_AAAA, 0, 1'b0);   // zero period acts as one
      send(48'h1357_9BDF_2468, 5, 1'b1);   // R9 start and input changes mid-frame
      send(48'hDEAD_BEEF_C0DE, 1, 1'b0);   // back-to-back for R7 gap

      while (busy || exp_q.size() > 0) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(busy == 1'b0, "R9 no extra frame", busy, 0);
      chk(frames_seen == frames_sent, "R9 frame count", frames_seen, frames_sent);
      chk(!idle_clk_bad, "R5 sclk low while select high", idle_clk_bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule